// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept, looking only at its destination address. The six destination bytes arrive one per accepted cycle on a byte stream, first byte first, after a frame-start pulse. As the bytes arrive, the block compares them with the programmed station address and with the all-ones broadcast address. In parallel it runs a CRC over the address to index a 64-bit multicast hash table.

One cycle after the sixth byte, the block raises a one-cycle valid strobe. With it come an accept/reject decision and a flag that marks group (multicast) destinations. The decision also applies three controls: promiscuous mode, broadcast enable and runt acceptance. The frame length is supplied by the surrounding receive logic and is sampled together with the sixth byte.

The filter keeps no address storage. Each byte is folded into running match flags and into the CRC as it arrives, so the decision needs only one register stage after the last byte.

Top module: `eth_dest_filter`

## Requirements
- R1: After reset, `decision_valid_o`, `accept_o` and `multicast_o` are all low.
- R2: `decision_valid_o` is high for exactly one cycle, in the cycle after the sixth destination byte following a frame start. Bytes beyond the sixth are ignored and produce no further strobe until the next frame start.
- R3: A `sof_i` pulse discards any partially received address. The next six bytes form a fresh address, and a byte presented in the same cycle as `sof_i` counts as byte 0.
- R4: With `promisc_i` set at the sixth byte, every frame that passes the length rule is accepted, whatever its destination.
- R5: Outside promiscuous mode, an all-ones destination (FF in all six bytes) is accepted only when `bcast_en_i` is high.
- R6: Outside promiscuous mode, a non-broadcast destination whose byte 0 has bit 0 set is accepted only when `hash_table_i[idx]` is 1. Here `idx` is the 6-bit hash index, so table byte `idx[5:3]` and bit `idx[2:0]` are selected.
- R7: The hash index is bits 31:26 of a 32-bit CRC that is set to all ones at frame start. The CRC takes byte 0 to byte 5, each least significant bit first. Per bit, carry = CRC[31] XOR data bit; the CRC shifts left one place; if carry is 1, it is XORed with 0x04C11DB6 and then bit 0 is forced to 1.
- R8: Outside promiscuous mode, a destination with byte 0 bit 0 clear is accepted only when byte k equals `station_addr_i[8k+7:8k]` for every k from 0 to 5.
- R9: If `frame_len_i` sampled at the sixth byte is below 60 and `runt_ok_i` is low, the frame is rejected in every mode. A length of exactly 60 passes the length rule.
- R10: `multicast_o`, valid with the strobe, is high when byte 0 bit 0 is set and the destination is not all ones, whether or not the frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Frame-start pulse; restarts address collection |
| byte_valid_i | input | 1 | Destination byte present on `byte_i` |
| byte_i | input | 8 | Destination address byte, byte 0 first |
| frame_len_i | input | 16 | Frame length in bytes, sampled with the sixth byte |
| promisc_i | input | 1 | Accept every destination |
| bcast_en_i | input | 1 | Accept the broadcast address |
| runt_ok_i | input | 1 | Accept frames shorter than 60 bytes |
| station_addr_i | input | 48 | Station address, byte k in bits 8k+7:8k |
| hash_table_i | input | 64 | Multicast hash table, bit index equals hash index |
| decision_valid_o | output | 1 | One-cycle strobe qualifying the decision |
| accept_o | output | 1 | Frame accepted |
| multicast_o | output | 1 | Destination is a non-broadcast group address |

## Verification
A wrong byte count shows up directly at the ports: the strobe arrives early, late, twice, or after a restarted address. It is visible in the cycle after the sixth byte. A corrupted CRC step or a wrong table-bit mapping only shows when a group address is filtered. So the bench sets a single table bit at the index it computes independently, then sets only the neighbouring bit, and the decision for that frame reveals any error. Stale match flags carried over a frame start would accept a mismatched unicast or reject a matching one on the very next decision.

// File: rtl/eth_dest_filter_pkg.sv
package eth_dest_filter_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned HASH_BITS  = 6;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned MIN_LEN    = 60;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB6;

  // One byte folded into the hash CRC, LSB first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] crc_in,
                                                     input logic [BYTE_W-1:0] data);
    logic [CRC_W-1:0] c;
    logic carry;
    c = crc_in;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      carry = c[CRC_W-1] ^ data[i];
      c = {c[CRC_W-2:0], 1'b0};
      if (carry) c = (c ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
    end
    return c;
  endfunction
endpackage

// File: rtl/addr_crc_hash.sv
module addr_crc_hash
  import eth_dest_filter_pkg::*;
#(
  parameter int unsigned HBITS = HASH_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [HBITS-1:0]  hash_idx_o
);
  logic [CRC_W-1:0] crc_q, crc_base, crc_d;

  assign crc_base = clear_i ? '1 : crc_q;
  assign crc_d    = step_i ? crc_fold_byte(crc_base, data_i) : crc_base;
  // index of the byte being stepped now, usable in the same cycle
  assign hash_idx_o = crc_d[CRC_W-1 -: HBITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_d;
  end
endmodule

// File: rtl/addr_match.sv
module addr_match
  import eth_dest_filter_pkg::*;
#(
  parameter int unsigned NBYTES = ADDR_BYTES,
  localparam int unsigned IDX_W = $clog2(NBYTES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     step_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [BYTE_W-1:0]        data_i,
  input  logic [NBYTES*BYTE_W-1:0] station_i,
  output logic                     uni_hit_o,
  output logic                     bcast_hit_o,
  output logic                     group_o
);
  logic uni_q, bcast_q, group_q;
  logic uni_b, bcast_b, group_b;
  logic [BYTE_W-1:0] st_byte;

  always_comb begin
    st_byte = '0;
    for (int k = 0; k < int'(NBYTES); k++)
      if (idx_i == IDX_W'(k)) st_byte = station_i[k*BYTE_W +: BYTE_W];
  end

  assign uni_b   = clear_i ? 1'b1 : uni_q;
  assign bcast_b = clear_i ? 1'b1 : bcast_q;
  assign group_b = clear_i ? 1'b0 : group_q;

  assign uni_hit_o   = step_i ? (uni_b && data_i == st_byte) : uni_b;
  assign bcast_hit_o = step_i ? (bcast_b && data_i == '1)    : bcast_b;
  assign group_o     = (step_i && idx_i == '0) ? data_i[0]   : group_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uni_q   <= 1'b0;
      bcast_q <= 1'b0;
      group_q <= 1'b0;
    end else begin
      uni_q   <= uni_hit_o;
      bcast_q <= bcast_hit_o;
      group_q <= group_o;
    end
  end
endmodule

// File: rtl/filter_decide.sv
module filter_decide
  import eth_dest_filter_pkg::*;
#(
  parameter int unsigned LW   = LEN_W,
  parameter int unsigned MINL = MIN_LEN
) (
  input  logic          uni_hit_i,
  input  logic          bcast_hit_i,
  input  logic          group_i,
  input  logic          hash_bit_i,
  input  logic          promisc_i,
  input  logic          bcast_en_i,
  input  logic          runt_ok_i,
  input  logic [LW-1:0] len_i,
  output logic          accept_o,
  output logic          mcast_o
);
  logic len_ok, addr_ok;

  assign len_ok = runt_ok_i || (len_i >= LW'(MINL));

  always_comb begin
    if (promisc_i)        addr_ok = 1'b1;
    else if (bcast_hit_i) addr_ok = bcast_en_i;
    else if (group_i)     addr_ok = hash_bit_i;
    else                  addr_ok = uni_hit_i;
  end

  assign accept_o = len_ok && addr_ok;
  assign mcast_o  = group_i && !bcast_hit_i;
endmodule

// File: rtl/eth_dest_filter.sv
module eth_dest_filter
  import eth_dest_filter_pkg::*;
#(
  parameter int unsigned NBYTES = ADDR_BYTES,
  parameter int unsigned HBITS  = HASH_BITS,
  parameter int unsigned LW     = LEN_W,
  parameter int unsigned MINL   = MIN_LEN,
  localparam int unsigned CNT_W = $clog2(NBYTES + 1),
  localparam int unsigned TBL_W = 1 << HBITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sof_i,
  input  logic                     byte_valid_i,
  input  logic [BYTE_W-1:0]        byte_i,
  input  logic [LW-1:0]            frame_len_i,
  input  logic                     promisc_i,
  input  logic                     bcast_en_i,
  input  logic                     runt_ok_i,
  input  logic [NBYTES*BYTE_W-1:0] station_addr_i,
  input  logic [TBL_W-1:0]         hash_table_i,
  output logic                     decision_valid_o,
  output logic                     accept_o,
  output logic                     multicast_o
);
  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic take, last;
  logic uni_hit, bcast_hit, group;
  logic [HBITS-1:0] hash_idx;
  logic acc_d, mc_d;

  assign cnt_base = sof_i ? '0 : cnt_q;
  assign take     = byte_valid_i && (cnt_base < CNT_W'(NBYTES));
  assign last     = take && (cnt_base == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= CNT_W'(NBYTES);
    else if (take) cnt_q <= cnt_base + 1'b1;
    else           cnt_q <= cnt_base;
  end

  addr_crc_hash #(.HBITS(HBITS)) u_hash (
    .clk_i, .rst_ni,
    .clear_i    (sof_i),
    .step_i     (take),
    .data_i     (byte_i),
    .hash_idx_o (hash_idx)
  );

  addr_match #(.NBYTES(NBYTES)) u_match (
    .clk_i, .rst_ni,
    .clear_i     (sof_i),
    .step_i      (take),
    .idx_i       (cnt_base),
    .data_i      (byte_i),
    .station_i   (station_addr_i),
    .uni_hit_o   (uni_hit),
    .bcast_hit_o (bcast_hit),
    .group_o     (group)
  );

  filter_decide #(.LW(LW), .MINL(MINL)) u_decide (
    .uni_hit_i   (uni_hit),
    .bcast_hit_i (bcast_hit),
    .group_i     (group),
    .hash_bit_i  (hash_table_i[hash_idx]),
    .promisc_i,
    .bcast_en_i,
    .runt_ok_i,
    .len_i       (frame_len_i),
    .accept_o    (acc_d),
    .mcast_o     (mc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
      multicast_o      <= 1'b0;
    end else begin
      decision_valid_o <= last;
      if (last) begin
        accept_o    <= acc_d;
        multicast_o <= mc_d;
      end
    end
  end
endmodule

// File: rtl/eth_dest_filter_chk.sv
module eth_dest_filter_chk
  import eth_dest_filter_pkg::*;
#(
  parameter int unsigned NBYTES = ADDR_BYTES,
  parameter int unsigned LW     = LEN_W,
  parameter int unsigned MINL   = MIN_LEN
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sof_i,
  input logic          byte_valid_i,
  input logic [LW-1:0] frame_len_i,
  input logic          promisc_i,
  input logic          runt_ok_i,
  input logic          decision_valid_o,
  input logic          accept_o
);
  int unsigned seen_q, seen_b;

  assign seen_b = sof_i ? 0 : seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              seen_q <= NBYTES;
    else if (byte_valid_i && seen_b < NBYTES) seen_q <= seen_b + 1;
    else                                      seen_q <= seen_b;
  end

  // R2
  strobe_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && seen_b == NBYTES - 1) |=> decision_valid_o);

  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);

  // R2
  strobe_needs_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> $past(byte_valid_i));

  // R9
  runt_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && $past(frame_len_i < LW'(MINL) && !runt_ok_i)) |-> !accept_o);

  // R4
  promisc_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && $past(promisc_i && (runt_ok_i || frame_len_i >= LW'(MINL))))
      |-> accept_o);
endmodule

bind eth_dest_filter eth_dest_filter_chk #(.NBYTES(NBYTES), .LW(LW), .MINL(MINL)) u_chk (
  .clk_i, .rst_ni, .sof_i, .byte_valid_i, .frame_len_i, .promisc_i, .runt_ok_i,
  .decision_valid_o, .accept_o
);

// File: tb/sim_eth_dest_filter.sv
module sim_eth_dest_filter;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [47:0] STATION = 48'h55_44_33_22_11_02;
  localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MCAST   = 48'h01_00_00_5E_00_01;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [15:0] frame_len_i = 16'd64;
  logic        promisc_i = 1'b0;
  logic        bcast_en_i = 1'b0;
  logic        runt_ok_i = 1'b0;
  logic [47:0] station_addr_i = STATION;
  logic [63:0] hash_table_i = '0;
  logic        decision_valid_o, accept_o, multicast_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  eth_dest_filter u0 (.*);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 8; j++) begin
        logic cy = c[31] ^ a[8*i + j];
        c = c << 1;
        if (cy) c = (c ^ 32'h04C1_1DB6) | 32'd1;
      end
    return c[31:26];
  endfunction

  task automatic start_frame();
    sof_i = 1'b1; byte_valid_i = 1'b0;
    @(negedge clk_i);
    sof_i = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic send_frame(input logic [47:0] a, input logic [15:0] len);
    frame_len_i = len;
    start_frame();
    for (int k = 0; k < 6; k++) put_byte(a[8*k +: 8]);
  endtask

  task automatic expect_dec(input string req, input logic acc, input logic mc);
    chk(req, "valid", decision_valid_o, 1'b1);
    chk(req, "accept", accept_o, acc);
    chk(req, "multicast", multicast_o, mc);
  endtask

  task automatic t_reset();
    chk("R1", "valid", decision_valid_o, 1'b0);
    chk("R1", "accept", accept_o, 1'b0);
    chk("R1", "multicast", multicast_o, 1'b0);
  endtask

  task automatic t_unicast();
    send_frame(STATION, 16'd64);
    expect_dec("R8", 1'b1, 1'b0);
    @(negedge clk_i);
    chk("R2", "valid one cycle", decision_valid_o, 1'b0);
    send_frame(STATION ^ 48'h01_00_00_00_00_00, 16'd64);
    expect_dec("R8", 1'b0, 1'b0);
    send_frame(STATION ^ 48'h00_00_00_00_00_10, 16'd64);
    expect_dec("R8", 1'b0, 1'b0);
  endtask

  task automatic t_broadcast();
    bcast_en_i = 1'b1;
    send_frame(BCAST, 16'd64);
    expect_dec("R5", 1'b1, 1'b0);
    bcast_en_i = 1'b0;
    send_frame(BCAST, 16'd64);
    expect_dec("R5", 1'b0, 1'b0);
  endtask

  task automatic t_multicast();
    logic [5:0] idx = ref_hash(MCAST);
    hash_table_i = 64'd1 << idx;
    send_frame(MCAST, 16'd64);
    expect_dec("R7", 1'b1, 1'b1);
    hash_table_i = 64'd1 << (idx ^ 6'd1);
    send_frame(MCAST, 16'd64);
    expect_dec("R6", 1'b0, 1'b1);
    hash_table_i = 64'd1 << (idx ^ 6'd8);
    send_frame(MCAST, 16'd64);
    expect_dec("R6", 1'b0, 1'b1);
    hash_table_i = ~(64'd1 << idx);
    send_frame(MCAST, 16'd64);
    expect_dec("R10", 1'b0, 1'b1);
    hash_table_i = '0;
  endtask

  task automatic t_promisc();
    promisc_i = 1'b1;
    send_frame(48'hA5_96_87_78_69_5A ^ 48'h0, 16'd64);
    expect_dec("R4", 1'b1, 1'b0);
    send_frame(MCAST, 16'd64);
    expect_dec("R4", 1'b1, 1'b1);
    send_frame(STATION, 16'd40);
    expect_dec("R9", 1'b0, 1'b0);
    promisc_i = 1'b0;
  endtask

  task automatic t_runt();
    send_frame(STATION, 16'd59);
    expect_dec("R9", 1'b0, 1'b0);
    send_frame(STATION, 16'd60);
    expect_dec("R9", 1'b1, 1'b0);
    runt_ok_i = 1'b1;
    send_frame(STATION, 16'd40);
    expect_dec("R9", 1'b1, 1'b0);
    runt_ok_i = 1'b0;
  endtask

  task automatic t_restart();
    frame_len_i = 16'd64;
    start_frame();
    for (int k = 0; k < 3; k++) put_byte(8'hFF);
    chk("R3", "no early valid", decision_valid_o, 1'b0);
    // sof together with byte 0
    sof_i = 1'b1;
    put_byte(STATION[7:0]);
    sof_i = 1'b0;
    for (int k = 1; k < 6; k++) begin
      chk("R3", "no valid mid address", decision_valid_o, 1'b0);
      put_byte(STATION[8*k +: 8]);
    end
    expect_dec("R3", 1'b1, 1'b0);
  endtask

  task automatic t_extra_bytes();
    send_frame(STATION, 16'd64);
    expect_dec("R2", 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      put_byte(8'hFF);
      chk("R2", "extra byte ignored", decision_valid_o, 1'b0);
    end
    @(negedge clk_i);
    chk("R2", "no late strobe", decision_valid_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_unicast();
    t_broadcast();
    t_multicast();
    t_promisc();
    t_runt();
    t_restart();
    t_extra_bytes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule